// File: doc/BRIEF.md
# Indirect Table Access Controller

This block gives a host processor byte-wide access to large internal tables that are too big to sit directly in the register map. The host sees a handful of 8-bit registers on a simple synchronous bus: a control byte, a low entry-index byte, a 67-bit data word spread over nine byte registers, and three scratch bytes that the block does not interpret.

The host first sets the control byte: direction, table, and the top two entry-index bits. For a write it also fills the data bytes. It then writes the low index byte, and that write starts the operation. The block presents one request on its table port, with the table select, 10-bit index, direction and payload held steady until the table acknowledges. On a read acknowledge, the returned payload is copied into the data registers.

Reads of the two slow tables (table codes 2 and 3) raise a busy flag that the host can poll. Reads of the fast tables (codes 0 and 1) and all writes never raise it.

Top module: `itab_host_ctl`

## Requirements
- R1: After reset every host register reads 0x00 and `tb_req` is low.
- R2: Addresses 0x76, 0x77 and 0x78 are independent 8-bit scratch registers that read back the last value written.
- R3: Address 0x79 (control) reads back all eight bits written, including the unused bits 7:5. Address 0x7A reads back the low index byte of the last accepted launch.
- R4: A host write to 0x7A while no request is outstanding raises `tb_req` on the next cycle. The request carries direction = control bit 4 (1 = read), table select = control bits 3:2, and index = {control bits 1:0, written byte}.
- R5: On a write command, `tb_wpay` equals {0x7B bits 2:0, 0x7C, 0x7D, … 0x83}, with 0x7C the most significant full byte. All request fields stay stable until `tb_ack`, and host writes to the data bytes during that time do not change them. `tb_req` falls in the cycle after the acknowledge.
- R6: On a read command, the payload on `tb_rpay` at the acknowledge is loaded into the data registers: bits 66:64 appear in 0x7B bits 2:0, and bits 63:0 appear in 0x7C..0x83, most significant byte first.
- R7: Bit 7 of 0x7B reads 1 from the cycle after a read of table 2 or 3 is launched until the acknowledge edge, and 0 afterwards. Bits 6:3 of 0x7B always read 0.
- R8: Reads of tables 0 and 1, and write commands to any table, never set bit 7 of 0x7B.
- R9: A write to 0x7A while a request is outstanding is ignored. No second request follows the acknowledge, and 0x7A keeps its earlier value.
- R10: `hb_rdata` is 0x00 when `hb_re` is low and for any unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_addr | input | 8 | Host register address |
| hb_wdata | input | 8 | Host write data |
| hb_we | input | 1 | Host write strobe |
| hb_re | input | 1 | Host read strobe |
| hb_rdata | output | 8 | Host read data, combinational from address |
| tb_req | output | 1 | Table request, held until acknowledged |
| tb_dir_rd | output | 1 | Request direction, 1 = read |
| tb_sel | output | 2 | Table select |
| tb_idx | output | 10 | Table entry index |
| tb_wpay | output | 67 | Write payload |
| tb_ack | input | 1 | Table acknowledge |
| tb_rpay | input | 67 | Read payload, valid with acknowledge |

## Verification
The bound checker watches the table handshake on every cycle. It checks that request fields hold until acknowledge, that the request drops right after acknowledge, and that each new request traces back to a host write of the low index byte. It also checks that the busy flag is only ever high during an outstanding slow-table read. Register readback values, byte ordering of the payload in both directions, and the silent rejection of a second launch are only visible through host-bus sequences, so the directed bench scenarios cover those.

// File: rtl/itab_pkg.sv
package itab_pkg;

  // host register map
  localparam logic [7:0] A_SCR0   = 8'h76;
  localparam logic [7:0] A_CTL    = 8'h79;
  localparam logic [7:0] A_IDX_LO = 8'h7A;
  localparam logic [7:0] A_DHI    = 8'h7B;
  localparam logic [7:0] A_DLO0   = 8'h7C;

  localparam int CTL_DIR_BIT = 4;

  typedef enum logic [1:0] {
    TBL_STATIC = 2'd0,
    TBL_VLAN   = 2'd1,
    TBL_DYN    = 2'd2,
    TBL_MIB    = 2'd3
  } tbl_e;

  // tables whose reads are slow enough to be polled
  function automatic logic f_polled(input logic [1:0] sel);
    return (sel == TBL_DYN) || (sel == TBL_MIB);
  endfunction

  // lowest payload bit of the byte at data window offset k
  function automatic int f_lane_lsb(input int k, input int nbytes);
    return 8 * (nbytes - 1 - k);
  endfunction

endpackage

// File: rtl/itab_regfile.sv
module itab_regfile
  import itab_pkg::*;
#(
  parameter int PAY_W = 67,
  parameter int N_SCR = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [7:0]              addr,
  input  logic [7:0]              wdata,
  input  logic                    lo_wr_ok,
  input  logic                    load_en,
  input  logic [PAY_W-1:0]        load_pay,
  output logic [N_SCR-1:0][7:0]   scr_o,
  output logic [7:0]              ctl_o,
  output logic [7:0]              idx_lo_o,
  output logic [PAY_W-1:0]        data_o
);
  localparam int LO_BYTES = (PAY_W - 1) / 8;
  localparam int HI_W     = PAY_W - 8 * LO_BYTES;

  logic [N_SCR-1:0][7:0] scr_q;
  logic [7:0]            ctl_q;
  logic [7:0]            idx_lo_q;
  logic [PAY_W-1:0]      data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q <= '0;
    end else if (we) begin
      for (int s = 0; s < N_SCR; s++) begin
        if (addr == A_SCR0 + 8'(s)) scr_q[s] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      idx_lo_q <= '0;
    end else begin
      if (we && addr == A_CTL) ctl_q <= wdata;
      if (lo_wr_ok)            idx_lo_q <= wdata;
    end
  end

  // table read data takes priority over a host byte write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load_en) begin
      data_q <= load_pay;
    end else if (we) begin
      if (addr == A_DHI) data_q[PAY_W-1 -: HI_W] <= wdata[HI_W-1:0];
      for (int k = 0; k < LO_BYTES; k++) begin
        if (addr == A_DLO0 + 8'(k))
          data_q[f_lane_lsb(k, LO_BYTES) +: 8] <= wdata;
      end
    end
  end

  assign scr_o    = scr_q;
  assign ctl_o    = ctl_q;
  assign idx_lo_o = idx_lo_q;
  assign data_o   = data_q;
endmodule

// File: rtl/itab_seq.sv
module itab_seq
  import itab_pkg::*;
#(
  parameter int PAY_W = 67,
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic [4:0]        ctl_lo,
  input  logic [7:0]        wdata,
  input  logic [PAY_W-1:0]  data_i,
  input  logic              ack,
  input  logic [PAY_W-1:0]  rpay,
  output logic              req_o,
  output logic              dir_rd_o,
  output logic [1:0]        sel_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PAY_W-1:0]  pay_o,
  output logic              busy_o,
  output logic              launch_o,
  output logic              load_en_o,
  output logic [PAY_W-1:0]  load_pay_o
);
  localparam int HI_IDX = IDX_W - 8;

  logic              req_q, dir_q, busy_q;
  logic [1:0]        sel_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PAY_W-1:0]  pay_q;
  logic              launch, done;

  assign launch = lo_wr && !req_q;
  assign done   = req_q && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      dir_q  <= 1'b0;
      busy_q <= 1'b0;
      sel_q  <= '0;
      idx_q  <= '0;
      pay_q  <= '0;
    end else if (launch) begin
      req_q  <= 1'b1;
      dir_q  <= ctl_lo[CTL_DIR_BIT];
      sel_q  <= ctl_lo[3:2];
      idx_q  <= {ctl_lo[HI_IDX-1:0], wdata};
      pay_q  <= data_i;
      busy_q <= ctl_lo[CTL_DIR_BIT] && f_polled(ctl_lo[3:2]);
    end else if (done) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
    end
  end

  assign req_o      = req_q;
  assign dir_rd_o   = dir_q;
  assign sel_o      = sel_q;
  assign idx_o      = idx_q;
  assign pay_o      = pay_q;
  assign busy_o     = busy_q;
  assign launch_o   = launch;
  assign load_en_o  = done && dir_q;
  assign load_pay_o = rpay;
endmodule

// File: rtl/itab_rdmux.sv
module itab_rdmux
  import itab_pkg::*;
#(
  parameter int PAY_W = 67,
  parameter int N_SCR = 3
) (
  input  logic                   re,
  input  logic [7:0]             addr,
  input  logic [N_SCR-1:0][7:0]  scr,
  input  logic [7:0]             ctl,
  input  logic [7:0]             idx_lo,
  input  logic [PAY_W-1:0]       data,
  input  logic                   busy,
  output logic [7:0]             rdata
);
  localparam int LO_BYTES = (PAY_W - 1) / 8;
  localparam int HI_W     = PAY_W - 8 * LO_BYTES;

  always_comb begin
    rdata = '0;
    if (re) begin
      for (int s = 0; s < N_SCR; s++) begin
        if (addr == A_SCR0 + 8'(s)) rdata = scr[s];
      end
      if (addr == A_CTL)    rdata = ctl;
      if (addr == A_IDX_LO) rdata = idx_lo;
      if (addr == A_DHI)    rdata = {busy, {(7-HI_W){1'b0}}, data[PAY_W-1 -: HI_W]};
      for (int k = 0; k < LO_BYTES; k++) begin
        if (addr == A_DLO0 + 8'(k)) rdata = data[f_lane_lsb(k, LO_BYTES) +: 8];
      end
    end
  end
endmodule

// File: rtl/itab_host_ctl.sv
module itab_host_ctl
  import itab_pkg::*;
#(
  parameter int PAY_W = 67,
  parameter int IDX_W = 10,
  parameter int N_SCR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        hb_addr,
  input  logic [7:0]        hb_wdata,
  input  logic              hb_we,
  input  logic              hb_re,
  output logic [7:0]        hb_rdata,
  output logic              tb_req,
  output logic              tb_dir_rd,
  output logic [1:0]        tb_sel,
  output logic [IDX_W-1:0]  tb_idx,
  output logic [PAY_W-1:0]  tb_wpay,
  input  logic              tb_ack,
  input  logic [PAY_W-1:0]  tb_rpay
);
  logic                  lo_wr_w;
  logic                  launch_w;
  logic                  busy_w;
  logic                  load_en_w;
  logic [PAY_W-1:0]      load_pay_w;
  logic [N_SCR-1:0][7:0] scr_w;
  logic [7:0]            ctl_w;
  logic [7:0]            idx_lo_w;
  logic [PAY_W-1:0]      data_w;

  assign lo_wr_w = hb_we && (hb_addr == A_IDX_LO);

  itab_regfile #(.PAY_W(PAY_W), .N_SCR(N_SCR)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (hb_we),
    .addr     (hb_addr),
    .wdata    (hb_wdata),
    .lo_wr_ok (launch_w),
    .load_en  (load_en_w),
    .load_pay (load_pay_w),
    .scr_o    (scr_w),
    .ctl_o    (ctl_w),
    .idx_lo_o (idx_lo_w),
    .data_o   (data_w)
  );

  itab_seq #(.PAY_W(PAY_W), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_wr      (lo_wr_w),
    .ctl_lo     (ctl_w[4:0]),
    .wdata      (hb_wdata),
    .data_i     (data_w),
    .ack        (tb_ack),
    .rpay       (tb_rpay),
    .req_o      (tb_req),
    .dir_rd_o   (tb_dir_rd),
    .sel_o      (tb_sel),
    .idx_o      (tb_idx),
    .pay_o      (tb_wpay),
    .busy_o     (busy_w),
    .launch_o   (launch_w),
    .load_en_o  (load_en_w),
    .load_pay_o (load_pay_w)
  );

  itab_rdmux #(.PAY_W(PAY_W), .N_SCR(N_SCR)) u_rd (
    .re     (hb_re),
    .addr   (hb_addr),
    .scr    (scr_w),
    .ctl    (ctl_w),
    .idx_lo (idx_lo_w),
    .data   (data_w),
    .busy   (busy_w),
    .rdata  (hb_rdata)
  );
endmodule

// File: rtl/itab_chk.sv
module itab_chk #(
  parameter int PAY_W = 67,
  parameter int IDX_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hb_we,
  input logic [7:0]        hb_addr,
  input logic              tb_req,
  input logic              tb_ack,
  input logic              tb_dir_rd,
  input logic [1:0]        tb_sel,
  input logic [IDX_W-1:0]  tb_idx,
  input logic [PAY_W-1:0]  tb_wpay,
  input logic              busy,
  input logic              launch
);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tb_req && !tb_ack |=> tb_req && $stable(tb_idx) && $stable(tb_sel)
                          && $stable(tb_dir_rd) && $stable(tb_wpay));

  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tb_req && tb_ack |=> !tb_req);

  p_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> tb_req);

  p_req_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tb_req) |-> $past(hb_we) && ($past(hb_addr) == 8'h7A) && !$past(tb_req));

  p_busy_scope_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tb_req && tb_dir_rd && tb_sel[1]);

  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tb_req && !(tb_dir_rd && tb_sel[1]) |-> !busy);
endmodule

bind itab_host_ctl itab_chk #(.PAY_W(PAY_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hb_we     (hb_we),
  .hb_addr   (hb_addr),
  .tb_req    (tb_req),
  .tb_ack    (tb_ack),
  .tb_dir_rd (tb_dir_rd),
  .tb_sel    (tb_sel),
  .tb_idx    (tb_idx),
  .tb_wpay   (tb_wpay),
  .busy      (busy_w),
  .launch    (launch_w)
);

// File: tb/test_itab_host_ctl.sv
`timescale 1ns/1ps
module test_itab_host_ctl;
  localparam int PW = 67;
  localparam int IW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    hb_addr = '0;
  logic [7:0]    hb_wdata = '0;
  logic          hb_we = 1'b0;
  logic          hb_re = 1'b0;
  logic [7:0]    hb_rdata;
  logic          tb_req, tb_dir_rd;
  logic [1:0]    tb_sel;
  logic [IW-1:0] tb_idx;
  logic [PW-1:0] tb_wpay;
  logic          tb_ack = 1'b0;
  logic [PW-1:0] tb_rpay = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  itab_host_ctl i_itab_host_ctl (
    .clk(clk), .rst_n(rst_n), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
    .hb_we(hb_we), .hb_re(hb_re), .hb_rdata(hb_rdata),
    .tb_req(tb_req), .tb_dir_rd(tb_dir_rd), .tb_sel(tb_sel), .tb_idx(tb_idx),
    .tb_wpay(tb_wpay), .tb_ack(tb_ack), .tb_rpay(tb_rpay)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    hb_addr = a; hb_wdata = d; hb_we = 1'b1;
    @(negedge clk);
    hb_we = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    hb_addr = a; hb_re = 1'b1;
    #1 d = hb_rdata;
    hb_re = 1'b0;
  endtask

  task automatic read_payload(output logic [PW-1:0] v);
    logic [7:0] b;
    host_read(8'h7B, b);
    v[66:64] = b[2:0];
    for (int k = 0; k < 8; k++) begin
      host_read(8'h7C + 8'(k), b);
      v[63 - 8*k -: 8] = b;
    end
  endtask

  task automatic give_ack(input logic [PW-1:0] p);
    tb_ack = 1'b1; tb_rpay = p;
    @(negedge clk);
    tb_ack = 1'b0; tb_rpay = '0;
  endtask

  function automatic logic [PW-1:0] mk_pay(input logic [1:0] sel, input logic [IW-1:0] idx);
    logic [63:0] lo;
    lo = 64'h0123_4567_89AB_CDEF ^ {sel, 52'h0, idx};
    return {3'(idx[2:0] + 3'(sel)), lo};
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    check("R1 req after reset", tb_req, 1'b0);
    for (int a = 8'h76; a <= 8'h83; a++) begin
      host_read(8'(a), d);
      check("R1 reg after reset", d, 8'h00);
    end
  endtask

  task automatic t_scratch;
    logic [7:0] d;
    host_write(8'h76, 8'h3C);
    host_write(8'h77, 8'hA5);
    host_write(8'h78, 8'hF0);
    host_read(8'h76, d); check("R2 scratch0", d, 8'h3C);
    host_read(8'h77, d); check("R2 scratch1", d, 8'hA5);
    host_read(8'h78, d); check("R2 scratch2", d, 8'hF0);
  endtask

  task automatic t_ctl;
    logic [7:0] d;
    host_write(8'h79, 8'hE7);
    host_read(8'h79, d); check("R3 ctl readback", d, 8'hE7);
    check("R4 no launch from ctl write", tb_req, 1'b0);
  endtask

  task automatic t_write_cmd;
    logic [7:0]    d;
    logic [PW-1:0] exp;
    host_write(8'h7B, 8'h05);
    for (int k = 0; k < 8; k++) host_write(8'h7C + 8'(k), 8'h10 + 8'(k));
    exp = {3'b101, 64'h1011_1213_1415_1617};
    host_write(8'h79, 8'h06);            // write, table 1, index hi 2
    host_write(8'h7A, 8'h5C);
    check("R4 req raised", tb_req, 1'b1);
    check("R4 dir write", tb_dir_rd, 1'b0);
    check("R4 sel", tb_sel, 2'd1);
    check("R4 idx", tb_idx, 10'h25C);
    check("R5 wpay order", tb_wpay, exp);
    host_read(8'h7B, d); check("R8 no busy on write", d, 8'h05);
    host_write(8'h83, 8'hFF);
    host_write(8'h7A, 8'h11);            // second launch while pending
    repeat (2) @(negedge clk);
    check("R5 held req", tb_req, 1'b1);
    check("R5 wpay stable", tb_wpay, exp);
    check("R9 idx unchanged", tb_idx, 10'h25C);
    give_ack('0);
    check("R5 req dropped", tb_req, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 no second request", tb_req, 1'b0);
    host_read(8'h7A, d); check("R9 lo byte kept", d, 8'h5C);
    host_read(8'h83, d); check("R5 write cmd leaves data", d, 8'hFF);
  endtask

  task automatic t_read(input logic [1:0] sel, input logic [1:0] hi, input logic [7:0] lo);
    logic [7:0]    d;
    logic [PW-1:0] p, got;
    logic          polled;
    polled = sel[1];
    p = mk_pay(sel, {hi, lo});
    host_write(8'h79, {3'b000, 1'b1, sel, hi});
    host_write(8'h7A, lo);
    check("R4 read req", tb_req, 1'b1);
    check("R4 dir read", tb_dir_rd, 1'b1);
    check("R4 read sel", tb_sel, sel);
    check("R4 read idx", tb_idx, {hi, lo});
    host_read(8'h7B, d);
    if (polled) check("R7 busy set", d[7:3], 5'b10000);
    else        check("R8 fast read no busy", d[7:3], 5'b00000);
    @(negedge clk);
    host_read(8'h7B, d);
    if (polled) check("R7 busy held", d[7], 1'b1);
    else        check("R8 fast read still no busy", d[7], 1'b0);
    give_ack(p);
    check("R5 req dropped after read", tb_req, 1'b0);
    host_read(8'h7B, d); check("R7 busy cleared", d[7:3], 5'b00000);
    read_payload(got);
    check("R6 payload loaded", got, p);
  endtask

  task automatic t_strobe;
    logic [7:0] d;
    @(negedge clk);
    hb_addr = 8'h76; hb_re = 1'b0;
    #1 check("R10 no strobe reads zero", hb_rdata, 8'h00);
    host_read(8'h00, d); check("R10 unmapped low", d, 8'h00);
    host_read(8'h84, d); check("R10 unmapped high", d, 8'h00);
    host_read(8'h75, d); check("R10 unmapped below scratch", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scratch();
    t_ctl();
    t_write_cmd();
    t_read(2'd2, 2'd1, 8'h3A);
    t_read(2'd3, 2'd3, 8'hFE);
    t_read(2'd0, 2'd0, 8'h07);
    t_read(2'd1, 2'd2, 8'h80);
    t_strobe();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule